// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a SPI master for serial flash parts, driven entirely by register writes. A host first loads a 32-bit transmit word, then writes a command word that selects a chip-select line, a transmit byte count, a receive byte count and one of three trigger bits. The engine drops the chosen chip select, clocks the command bytes out on MOSI, clocks the response bytes in from MISO, releases the chip select and raises a finished flag. The flag stays set until the host clears it.

Only SPI mode 3 is produced: SCK rests high, MOSI changes after falling edges and MISO is sampled on rising edges. Two shortcut triggers exist. The status trigger sends opcode 0x05 and collects a 16-bit status word. The write-enable trigger sends opcode 0x06 on its own. SCK is derived from the system clock with a programmable half-period, so the fastest SCK is one half of the system clock.

The controller is a four-state machine. The states are IDLE, SETUP (select asserted, SCK still high), SCK_LOW and SCK_HIGH. It has five transitions:
- launch: IDLE to SETUP, on an accepted trigger.
- lead-in: SETUP to SCK_LOW, after one half period.
- rise: SCK_LOW to SCK_HIGH, where MISO is sampled.
- next-bit: SCK_HIGH to SCK_LOW, where MOSI advances.
- finish: SCK_HIGH to IDLE, after the last bit.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: SCK is high and every `cs_n` bit is high whenever `busy` is low. During a transaction MOSI changes only at falling SCK edges, and MISO is sampled at rising SCK edges (mode 3).
- R2: A generic send with `cmd_txlen` = n sends n+1 bytes. The bytes come from the transmit register, starting at bits 31:24 and moving downward, each byte most significant bit first.
- R3: A generic send receives `cmd_rxlen` bytes (0 to 3). At completion `rx_data` holds them right-aligned: the first received byte is most significant and the unused upper bits are zero.
- R4: `cmd_rdstat` sends byte 0x05 and then receives two bytes. `stat_data[15:8]` gets the first byte and `stat_data[7:0]` the second. `rx_data` is left unchanged.
- R5: `cmd_wrenable` sends byte 0x06 alone: 8 SCK cycles and no receive phase. Both `rx_data` and `stat_data` are left unchanged.
- R6: When several trigger bits are set in one command write, the status trigger wins over write-enable, which wins over a generic send. A command write with no trigger bit set starts nothing.
- R7: `done` rises on the same clock edge on which `busy` falls at the end of a transaction. It stays high until a `done_clr` pulse clears it.
- R8: During a transaction only `cs_n[cmd_bank]` is low.
- R9: `cs_n` holds one value for the whole transaction. The number of rising SCK edges equals 8 times the sum of the transmit and receive byte counts.
- R10: `cs_n` falls one SCK half period before the first falling SCK edge. It rises one half period after the last rising SCK edge.
- R11: A command write while `busy` is high is ignored. The running transaction completes unchanged and no further transaction follows.
- R12: Each SCK half period lasts `sck_half` system clocks, with 0 treated as 1. The value is captured when a trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_wdata | input | 32 | Transmit register data, first byte in bits 31:24 |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_send | input | 1 | Generic transaction trigger |
| cmd_rdstat | input | 1 | Status-read trigger (opcode 0x05, two bytes in) |
| cmd_wrenable | input | 1 | Write-enable trigger (opcode 0x06) |
| cmd_bank | input | BANK_W | Chip-select index |
| cmd_txlen | input | 2 | Transmit byte count minus one |
| cmd_rxlen | input | 2 | Receive byte count, 0 to 3 |
| sck_half | input | DIV_W | SCK half period in system clocks |
| done_clr | input | 1 | Clears the finished flag |
| miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky transfer-finished flag |
| rx_data | output | 24 | Receive register of the generic send |
| stat_data | output | 16 | Status register of the status read |
| cs_n | output | NUM_CS | Active-low chip selects |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the flash |

## Verification
The embedded properties watch, on every cycle:
- that at most one select is low, and that it does not move while the state machine is away from IDLE;
- that SCK and the selects rest high while idle;
- that the finished flag appears exactly as busy drops and persists until cleared;
- that a command write during a transaction leaves the latched bank and lengths untouched.

Only the bench's scenarios can show the rest. It uses a mode-3 flash model on the serial lines. That model shows:
- the byte and bit ordering on MOSI;
- the right alignment of received bytes;
- the fixed opcodes and the trigger priority;
- the half-period spacing of SCK edges against the select.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SETUP    = 2'd1,
        ST_SCK_LOW  = 2'd2,
        ST_SCK_HIGH = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RX   = 2'd1,
        TGT_STAT = 2'd2
    } rx_target_e;

    localparam logic [7:0] OP_READ_STATUS  = 8'h05;
    localparam logic [7:0] OP_WRITE_ENABLE = 8'h06;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt >= half - ONE);
    assign tick = run && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // R12
    tick_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick || (half <= ONE));

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int TX_W = 32,
    parameter int RX_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            shift_en,
    input  logic            sample_en,
    input  logic            miso,
    output logic            mosi,
    output logic [RX_W-1:0] acc
);
    logic [TX_W-1:0] sr;

    assign mosi = sr[TX_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            acc <= '0;
        end else begin
            if (load) begin
                sr  <= load_word;
                acc <= '0;
            end else begin
                if (shift_en) begin
                    sr <= {sr[TX_W-2:0], 1'b0};
                end
                if (sample_en) begin
                    acc <= {acc[RX_W-2:0], miso};
                end
            end
        end
    end

    // R1
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(mosi));

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
    import spi_flash_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 8,
    localparam int BANK_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_send,
    input  logic              cmd_rdstat,
    input  logic              cmd_wrenable,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [1:0]        cmd_txlen,
    input  logic [1:0]        cmd_rxlen,
    input  logic [DIV_W-1:0]  sck_half,
    input  logic [31:0]       tx_word,
    input  logic              done_clr,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic [NUM_CS-1:0] cs_n,
    output logic              load,
    output logic [31:0]       load_word,
    output logic              shift_en,
    output logic              sample_en,
    output logic              finish,
    output rx_target_e        tgt,
    output logic [DIV_W-1:0]  half_q
);
    seq_state_e        state, state_nx;
    logic [BANK_W-1:0] bank_q;
    logic [5:0]        tx_bits_q, last_idx_q, bit_idx;
    logic [5:0]        go_txb, go_rxb;
    rx_target_e        go_tgt;
    logic              go, last_bit;

    // trigger decode: status read > write enable > generic send
    always_comb begin
        load_word = tx_word;
        go_txb    = {1'b0, {1'b0, cmd_txlen} + 3'd1, 2'b00} << 1;
        go_rxb    = {1'b0, cmd_rxlen, 3'b000};
        go_tgt    = TGT_RX;
        if (cmd_rdstat) begin
            load_word = {OP_READ_STATUS, 24'h0};
            go_txb    = 6'd8;
            go_rxb    = 6'd16;
            go_tgt    = TGT_STAT;
        end else if (cmd_wrenable) begin
            load_word = {OP_WRITE_ENABLE, 24'h0};
            go_txb    = 6'd8;
            go_rxb    = 6'd0;
            go_tgt    = TGT_NONE;
        end
    end

    assign go       = cmd_wr && (state == ST_IDLE) && (cmd_send || cmd_rdstat || cmd_wrenable);
    assign last_bit = (bit_idx == last_idx_q);
    assign load     = go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (go)   state_nx = ST_SETUP;
            ST_SETUP:    if (tick) state_nx = ST_SCK_LOW;
            ST_SCK_LOW:  if (tick) state_nx = ST_SCK_HIGH;
            ST_SCK_HIGH: if (tick) state_nx = last_bit ? ST_IDLE : ST_SCK_LOW;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        sck       = 1'b1;
        cs_n      = ~(NUM_CS'(1) << bank_q);
        shift_en  = 1'b0;
        sample_en = 1'b0;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                cs_n = '1;
            end
            ST_SETUP: ;
            ST_SCK_LOW: begin
                sck       = 1'b0;
                sample_en = tick && (bit_idx >= tx_bits_q);
            end
            ST_SCK_HIGH: begin
                shift_en = tick && !last_bit;
                finish   = tick && last_bit;
            end
        endcase
    end

    // transaction context and finished flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q     <= '0;
            tx_bits_q  <= '0;
            last_idx_q <= '0;
            bit_idx    <= '0;
            tgt        <= TGT_NONE;
            half_q     <= DIV_W'(1);
            done       <= 1'b0;
        end else begin
            if (go) begin
                bank_q     <= cmd_bank;
                tx_bits_q  <= go_txb;
                last_idx_q <= go_txb + go_rxb - 6'd1;
                bit_idx    <= '0;
                tgt        <= go_tgt;
                half_q     <= (sck_half == '0) ? DIV_W'(1) : sck_half;
            end else if (shift_en) begin
                bit_idx <= bit_idx + 6'd1;
            end
            if (finish)        done <= 1'b1;
            else if (done_clr) done <= 1'b0;
        end
    end

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R9
    cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cs_n));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(bank_q) && $stable(last_idx_q) && $stable(half_q)));

endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
    import spi_flash_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 8,
    localparam int BANK_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [31:0]       tx_wdata,
    input  logic              cmd_wr,
    input  logic              cmd_send,
    input  logic              cmd_rdstat,
    input  logic              cmd_wrenable,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [1:0]        cmd_txlen,
    input  logic [1:0]        cmd_rxlen,
    input  logic [DIV_W-1:0]  sck_half,
    input  logic              done_clr,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [23:0]       rx_data,
    output logic [15:0]       stat_data,
    output logic [NUM_CS-1:0] cs_n,
    output logic              sck,
    output logic              mosi
);
    logic [31:0]      tx_q;
    logic             tick, load, shift_en, sample_en, finish;
    logic [31:0]      load_word;
    logic [23:0]      acc;
    logic [DIV_W-1:0] half_q;
    rx_target_e       tgt;

    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (tx_wr) tx_q <= tx_wdata;
    end

    spi_seq_fsm #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_send(cmd_send), .cmd_rdstat(cmd_rdstat),
        .cmd_wrenable(cmd_wrenable), .cmd_bank(cmd_bank),
        .cmd_txlen(cmd_txlen), .cmd_rxlen(cmd_rxlen), .sck_half(sck_half),
        .tx_word(tx_q), .done_clr(done_clr), .tick(tick),
        .busy(busy), .done(done), .sck(sck), .cs_n(cs_n),
        .load(load), .load_word(load_word), .shift_en(shift_en),
        .sample_en(sample_en), .finish(finish), .tgt(tgt), .half_q(half_q)
    );

    spi_half_tick #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q), .tick(tick)
    );

    spi_shift_path #(.TX_W(32), .RX_W(24)) i_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
        .shift_en(shift_en), .sample_en(sample_en), .miso(miso),
        .mosi(mosi), .acc(acc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            stat_data <= '0;
        end else if (finish) begin
            if (tgt == TGT_RX)        rx_data   <= acc;
            else if (tgt == TGT_STAT) stat_data <= acc[15:0];
        end
    end

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck && (&cs_n)));

endmodule

// File: tb/test_spi_flash_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_flash_cmd_engine;

    typedef struct packed {
        logic [1:0]  kind;   // 0 generic send, 1 status read, 2 write enable
        logic [31:0] word;
        logic [1:0]  txcode;
        logic [1:0]  rxl;
        logic [1:0]  bank;
        logic [3:0]  half;
        logic [23:0] resp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h9F00_0000, 2'd0, 2'd3, 2'd0, 4'd1, 24'h20BA18},
        '{2'd0, 32'hD812_3456, 2'd3, 2'd0, 2'd1, 4'd2, 24'h000000},
        '{2'd0, 32'h0BA5_5A00, 2'd1, 2'd2, 2'd2, 4'd3, 24'h55C3E1},
        '{2'd1, 32'h0000_0000, 2'd0, 2'd0, 2'd3, 4'd1, 24'h008142},
        '{2'd2, 32'h0000_0000, 2'd0, 2'd0, 2'd0, 4'd0, 24'h000000},
        '{2'd0, 32'h03AB_CDEF, 2'd2, 2'd1, 2'd1, 4'd2, 24'hFFFF7E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        cmd_wr = 1'b0, cmd_send = 1'b0, cmd_rdstat = 1'b0, cmd_wrenable = 1'b0;
    logic [1:0]  cmd_bank = '0, cmd_txlen = '0, cmd_rxlen = '0;
    logic [7:0]  sck_half = 8'd1;
    logic        done_clr = 1'b0;
    logic        miso = 1'b1;
    logic        busy, done, sck, mosi;
    logic [23:0] rx_data;
    logic [15:0] stat_data;
    logic [3:0]  cs_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_flash_cmd_engine #(.NUM_CS(4), .DIV_W(8)) i_spi_flash_cmd_engine (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .cmd_wr(cmd_wr), .cmd_send(cmd_send), .cmd_rdstat(cmd_rdstat),
        .cmd_wrenable(cmd_wrenable), .cmd_bank(cmd_bank), .cmd_txlen(cmd_txlen),
        .cmd_rxlen(cmd_rxlen), .sck_half(sck_half), .done_clr(done_clr),
        .miso(miso), .busy(busy), .done(done), .rx_data(rx_data),
        .stat_data(stat_data), .cs_n(cs_n), .sck(sck), .mosi(mosi)
    );

    // mode-3 flash model
    int          s_txb = 8, s_rxb = 0;
    logic [23:0] s_resp = '0;
    logic        in_txn = 1'b0, last_sck = 1'b1;
    int          k = 0, edges = 0;
    logic [63:0] cap = '0;
    logic [3:0]  cs_val = '1;
    time         t_cs_fall = 0, t_fall0 = 0, t_rise0 = 0, t_last_rise = 0, t_cs_rise = 0;
    logic        all_hi;
    assign all_hi = &cs_n;

    always @(sck or all_hi) begin
        if (all_hi) begin
            if (in_txn) begin
                in_txn    = 1'b0;
                t_cs_rise = $time;
            end
        end else if (!in_txn) begin
            in_txn = 1'b1; k = 0; edges = 0; cap = '0;
            cs_val = cs_n; t_cs_fall = $time; last_sck = sck;
        end else if (sck != last_sck) begin
            last_sck = sck;
            if (!sck) begin
                if (k == 0) t_fall0 = $time;
                if (k >= s_txb && k < s_txb + s_rxb) miso = s_resp[s_rxb - 1 - (k - s_txb)];
                else                                 miso = 1'b1;
                k = k + 1;
            end else begin
                if (edges == 0) t_rise0 = $time;
                t_last_rise = $time;
                cap   = {cap[62:0], mosi};
                edges = edges + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic s, input logic r, input logic w, input logic [31:0] word,
                         input logic [1:0] code, input logic [1:0] rxl, input logic [1:0] bank,
                         input logic [7:0] half);
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = word;
        @(negedge clk);
        tx_wr = 1'b0;
        cmd_wr = 1'b1; cmd_send = s; cmd_rdstat = r; cmd_wrenable = w;
        cmd_txlen = code; cmd_rxlen = rxl; cmd_bank = bank; sck_half = half;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_send = 1'b0; cmd_rdstat = 1'b0; cmd_wrenable = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] exp_rx;
        logic [15:0] exp_st;
        exp_rx = '0; exp_st = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1", "reset sck", {63'd0, sck}, 64'd1);
        chk("R1", "reset cs_n", {60'd0, cs_n}, 64'hF);
        chk("R7", "reset done", {63'd0, done}, 64'd0);
        chk("R11", "reset busy", {63'd0, busy}, 64'd0);
        chk("R3", "reset rx_data", {40'd0, rx_data}, 64'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int txb, rxb, heff;
            logic [63:0] exp_tx, txcap;
            vec_t cv;
            cv   = VECS[v];
            txb  = (cv.kind == 2'd0) ? 8 * (int'(cv.txcode) + 1) : 8;
            rxb  = (cv.kind == 2'd0) ? 8 * int'(cv.rxl) : ((cv.kind == 2'd1) ? 16 : 0);
            heff = (cv.half == 4'd0) ? 1 : int'(cv.half);
            exp_tx = (cv.kind == 2'd1) ? 64'h05 :
                     (cv.kind == 2'd2) ? 64'h06 : 64'(cv.word >> (32 - txb));
            s_txb = txb; s_rxb = rxb; s_resp = cv.resp;
            issue(cv.kind == 2'd0, cv.kind == 2'd1, cv.kind == 2'd2, cv.word,
                  cv.txcode, cv.rxl, cv.bank, {4'd0, cv.half});
            wait_idle();
            @(negedge clk);
            if (cv.kind == 2'd0) exp_rx = 24'(cv.resp & ((24'd1 << rxb) - 24'd1));
            if (cv.kind == 2'd1) exp_st = cv.resp[15:0];
            txcap = (cap >> rxb) & ((64'd1 << txb) - 64'd1);
            chk("R9", "sck rising edges", 64'(edges), 64'(txb + rxb));
            chk(cv.kind == 2'd1 ? "R4" : (cv.kind == 2'd2 ? "R5" : "R2"), "mosi bytes", txcap, exp_tx);
            chk("R8", "active cs_n", {60'd0, cs_val}, {60'd0, ~(4'd1 << cv.bank)});
            chk("R3", "rx_data", {40'd0, rx_data}, {40'd0, exp_rx});
            chk("R4", "stat_data", {48'd0, stat_data}, {48'd0, exp_st});
            chk("R7", "done after finish", {62'd0, done, busy}, 64'b10);
            chk("R10", "cs to first fall", 64'(t_fall0 - t_cs_fall), 64'(8 * heff));
            chk("R12", "half period", 64'(t_rise0 - t_fall0), 64'(8 * heff));
            chk("R10", "last rise to cs", 64'(t_cs_rise - t_last_rise), 64'(8 * heff));
            pulse_clr();
        end

        // R7 sticky flag and clear
        s_txb = 8; s_rxb = 0;
        issue(1'b0, 1'b0, 1'b1, 32'h0, 2'd0, 2'd0, 2'd2, 8'd1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R7", "done held while idle", {63'd0, done}, 64'd1);
        pulse_clr();
        chk("R7", "done after clear", {63'd0, done}, 64'd0);

        // R6 no trigger bit: nothing starts
        issue(1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 2'd3, 2'd3, 2'd1, 8'd1);
        repeat (5) @(negedge clk);
        chk("R6", "no trigger busy", {63'd0, busy}, 64'd0);
        chk("R6", "no trigger cs_n", {60'd0, cs_n}, 64'hF);
        chk("R6", "no trigger done", {63'd0, done}, 64'd0);

        // R6 priority: all bits set, status read wins
        s_txb = 8; s_rxb = 16; s_resp = 24'h00A55A;
        issue(1'b1, 1'b1, 1'b1, 32'h9F00_0000, 2'd0, 2'd3, 2'd2, 8'd1);
        wait_idle();
        @(negedge clk);
        chk("R6", "priority edges", 64'(edges), 64'd24);
        chk("R6", "priority opcode", (cap >> 16) & 64'hFF, 64'h05);
        chk("R6", "priority stat_data", {48'd0, stat_data}, 64'hA55A);
        chk("R6", "priority rx_data untouched", {40'd0, rx_data}, {40'd0, exp_rx});
        exp_st = 16'hA55A;
        pulse_clr();

        // R11 command write while busy is ignored
        s_txb = 8; s_rxb = 8; s_resp = 24'h0000C7;
        issue(1'b1, 1'b0, 1'b0, 32'hAB00_0000, 2'd0, 2'd1, 2'd2, 8'd2);
        repeat (4) @(negedge clk);
        cmd_wr = 1'b1; cmd_rdstat = 1'b1; cmd_bank = 2'd3; sck_half = 8'd5;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_rdstat = 1'b0;
        wait_idle();
        @(negedge clk);
        chk("R11", "edges unchanged", 64'(edges), 64'd16);
        chk("R11", "bank unchanged", {60'd0, cs_val}, 64'hB);
        chk("R11", "rx_data", {40'd0, rx_data}, 64'hC7);
        repeat (20) @(negedge clk);
        chk("R11", "no follow-on busy", {63'd0, busy}, 64'd0);
        chk("R11", "stat_data untouched", {48'd0, stat_data}, {48'd0, exp_st});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule